// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block collects three level-sensitive event lines from a packet interface: frame received, frame sent and send failure. It folds them into one interrupt request for a host processor. Software never writes the enable mask directly. It owns two write-only strobe registers, one that turns mask bits on and one that turns them off, and it reads the resulting mask through a separate read-only view. A fourth register shows which sources are latched as pending; a 1 written there releases the latch.

Each source has a pending bit. The bit latches while its line is high and enabled, and it stays set until software releases it, even if the line falls or the source is later disabled. Releasing a pending bit sends a single-cycle acknowledge back to that source, so the source can drop its request. If the source line is still high after the acknowledge, the bit latches again. The mask is also driven out to the sources, so each one can see whether it is being listened to.

The block takes a register strobe that an outer address decoder has already qualified. It also takes a two-bit word index within its four-word window (0 = disable, 1 = enable, 2 = mask view, 3 = pending) and the write data. Read data is a combinational function of the index.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset the mask, pending bits, acknowledge outputs and interrupt output are all 0, and every index reads 0.
- R2: A write to index 1 sets each mask bit whose write-data bit is 1 (bit 0 receive, bit 1 transmit, bit 2 transmit error); 0 bits and data bits above bit 2 change nothing.
- R3: A write to index 0 clears each mask bit whose write-data bit is 1; 0 bits change nothing.
- R4: Index 2 reads the mask in bits [2:0] with all upper bits 0, and `src_mask` always equals the mask.
- R5: Indexes 0 and 1 read as 0 whatever the mask holds.
- R6: A pending bit becomes 1 at the clock edge where its line is high and its mask bit was already 1; a masked source never becomes pending. A pending bit stays 1 after its line falls or its mask bit is cleared.
- R7: Index 3 reads the pending bits in [2:0]. A write of 1 to a bit there clears it at that edge, and this takes priority over a line still high. A written 0 has no effect.
- R8: `irq` is 1 exactly when at least one pending bit is 1.
- R9: A pending-register write pulses `src_ack` for one cycle after the edge, only for bits that were pending and written 1. A line still high and enabled sets its pending bit again one cycle later.
- R10: A write to index 2, or a cycle with `acc_sel` or `acc_we` low, changes neither the mask nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_sel | input | 1 | Register window selected by the outer decoder |
| acc_we | input | 1 | Write qualifier |
| acc_idx | input | 2 | Word index within the window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_idx` |
| src_lvl | input | 3 | Source request lines, active high |
| src_mask | output | 3 | Current enable mask toward the sources |
| src_ack | output | 3 | One-cycle release acknowledge per source |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted mask bit shows up on `src_mask` and the index-2 read in the same cycle. It also shows up one edge later when an enabled line fails to latch, or a disabled line latches. A pending bit stuck high keeps `irq` asserted after a full release, and one stuck low leaves `irq` low for a cycle in which a line was high and enabled. An acknowledge tied to the wrong bit, or one lasting longer than a cycle, appears on `src_ack` in the cycle right after the release write. A missing re-latch shows one cycle after that.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;

  localparam int IDX_W   = 2;
  localparam int SRC_MAX = 8;

  typedef logic [SRC_MAX-1:0] srcvec_t;

  typedef enum logic [IDX_W-1:0] {
    IDX_OFF  = 2'd0,
    IDX_ON   = 2'd1,
    IDX_MASK = 2'd2,
    IDX_PEND = 2'd3
  } reg_idx_e;

  // mask after one edge: on-strobe bits set, off-strobe bits cleared
  function automatic srcvec_t mask_next(srcvec_t cur, srcvec_t on, srcvec_t off);
    return (cur | on) & ~off;
  endfunction

  // one pending bit: release wins, otherwise latch an enabled high line
  function automatic logic pend_bit_next(logic cur, logic lvl, logic en, logic rel);
    if (rel) return 1'b0;
    return cur | (lvl & en);
  endfunction

  // acknowledge only when a latched bit is released
  function automatic logic ack_bit_next(logic cur, logic rel);
    return cur & rel;
  endfunction

endpackage

// File: rtl/irq_setclr_decode.sv
module irq_setclr_decode
  import irq_setclr_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic             sel,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [NSRC-1:0]  wbits,
  output logic [NSRC-1:0]  on_bits,
  output logic [NSRC-1:0]  off_bits,
  output logic [NSRC-1:0]  clr_bits
);

  logic wr;
  assign wr = sel & we;

  always_comb begin
    on_bits  = '0;
    off_bits = '0;
    clr_bits = '0;
    if (wr) begin
      case (idx)
        IDX_ON:   on_bits  = wbits;
        IDX_OFF:  off_bits = wbits;
        IDX_PEND: clr_bits = wbits;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/irq_setclr_mask.sv
module irq_setclr_mask
  import irq_setclr_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] on_bits,
  input  logic [NSRC-1:0] off_bits,
  output logic [NSRC-1:0] mask_q
);

  srcvec_t nxt_wide;
  assign nxt_wide = mask_next(srcvec_t'(mask_q), srcvec_t'(on_bits), srcvec_t'(off_bits));

  logic unused_nxt_hi;
  if (NSRC < SRC_MAX) begin : g_hi
    assign unused_nxt_hi = ^nxt_wide[SRC_MAX-1:NSRC];
  end else begin : g_nohi
    assign unused_nxt_hi = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= nxt_wide[NSRC-1:0];
  end

endmodule

// File: rtl/irq_setclr_pend.sv
module irq_setclr_pend
  import irq_setclr_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] ack_q
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        ack_q[i]  <= 1'b0;
      end else begin
        pend_q[i] <= pend_bit_next(pend_q[i], lvl[i], mask[i], clr_bits[i]);
        ack_q[i]  <= ack_bit_next(pend_q[i], clr_bits[i]);
      end
    end
  end

endmodule

// File: rtl/irq_setclr_rdmux.sv
module irq_setclr_rdmux
  import irq_setclr_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int DW   = 32
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [NSRC-1:0]  mask,
  input  logic [NSRC-1:0]  pend,
  output logic [DW-1:0]    rdata
);

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_MASK: rdata[NSRC-1:0] = mask;
      IDX_PEND: rdata[NSRC-1:0] = pend;
      default:  ;
    endcase
  end

endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl
  import irq_setclr_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int DW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_sel,
  input  logic             acc_we,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    acc_rdata,
  input  logic [NSRC-1:0]  src_lvl,
  output logic [NSRC-1:0]  src_mask,
  output logic [NSRC-1:0]  src_ack,
  output logic             irq
);

  logic [NSRC-1:0] on_bits;
  logic [NSRC-1:0] off_bits;
  logic [NSRC-1:0] clr_bits;
  logic [NSRC-1:0] mask_vec;
  logic [NSRC-1:0] pend_vec;

  logic unused_wdata_hi;
  if (DW > NSRC) begin : g_wd_hi
    assign unused_wdata_hi = ^acc_wdata[DW-1:NSRC];
  end else begin : g_wd_nohi
    assign unused_wdata_hi = 1'b0;
  end

  irq_setclr_decode #(.NSRC(NSRC)) u_dec (
    .sel      (acc_sel),
    .we       (acc_we),
    .idx      (acc_idx),
    .wbits    (acc_wdata[NSRC-1:0]),
    .on_bits  (on_bits),
    .off_bits (off_bits),
    .clr_bits (clr_bits)
  );

  irq_setclr_mask #(.NSRC(NSRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .on_bits  (on_bits),
    .off_bits (off_bits),
    .mask_q   (mask_vec)
  );

  irq_setclr_pend #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (src_lvl),
    .mask     (mask_vec),
    .clr_bits (clr_bits),
    .pend_q   (pend_vec),
    .ack_q    (src_ack)
  );

  irq_setclr_rdmux #(.NSRC(NSRC), .DW(DW)) u_rd (
    .idx      (acc_idx),
    .mask     (mask_vec),
    .pend     (pend_vec),
    .rdata    (acc_rdata)
  );

  assign src_mask = mask_vec;
  assign irq      = |pend_vec;

endmodule

// File: rtl/irq_setclr_chk.sv
module irq_setclr_chk
  import irq_setclr_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int DW   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_sel,
  input logic             acc_we,
  input logic [IDX_W-1:0] acc_idx,
  input logic [DW-1:0]    acc_wdata,
  input logic [DW-1:0]    acc_rdata,
  input logic [NSRC-1:0]  src_lvl,
  input logic [NSRC-1:0]  src_mask,
  input logic [NSRC-1:0]  src_ack,
  input logic             irq,
  input logic [NSRC-1:0]  pend_vec
);

  logic wr, wr_on, wr_off, wr_view, wr_pend;
  assign wr      = acc_sel & acc_we;
  assign wr_on   = wr && (acc_idx == IDX_ON);
  assign wr_off  = wr && (acc_idx == IDX_OFF);
  assign wr_view = wr && (acc_idx == IDX_MASK);
  assign wr_pend = wr && (acc_idx == IDX_PEND);

  AST_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_on |=> ((src_mask & $past(acc_wdata[NSRC-1:0])) == $past(acc_wdata[NSRC-1:0]))); // R2
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> ((src_mask & $past(acc_wdata[NSRC-1:0])) == '0)); // R3
  AST_MASK_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_idx == IDX_MASK) |-> (acc_rdata == DW'(src_mask))); // R4
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_idx == IDX_ON) || (acc_idx == IDX_OFF)) |-> (acc_rdata == '0)); // R5
  AST_PEND_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~($past(src_mask) & $past(src_lvl))) == '0)); // R6
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_idx == IDX_PEND) |-> (irq == (acc_rdata != '0))); // R8
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack != '0) |-> $past(wr_pend)); // R9
  AST_ACK_WAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack != '0) |-> (((src_ack & ~$past(pend_vec)) == '0) && ((src_ack & pend_vec) == '0))); // R9
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack != '0) |=> ((src_ack & $past(src_ack)) == '0)); // R9
  AST_VIEW_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_view || !wr) |=> $stable(src_mask)); // R10

endmodule

bind irq_setclr_ctrl irq_setclr_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_sel   (acc_sel),
  .acc_we    (acc_we),
  .acc_idx   (acc_idx),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .src_lvl   (src_lvl),
  .src_mask  (src_mask),
  .src_ack   (src_ack),
  .irq       (irq),
  .pend_vec  (pend_vec)
);

// File: tb/irq_setclr_ctrl_test.sv
`timescale 1ns/1ps
module irq_setclr_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_sel = 1'b0;
  logic        acc_we = 1'b0;
  logic [1:0]  acc_idx = 2'd0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [2:0]  src_lvl = 3'b000;
  logic [2:0]  src_mask;
  logic [2:0]  src_ack;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_setclr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .src_lvl(src_lvl), .src_mask(src_mask), .src_ack(src_ack), .irq(irq)
  );

  // {we, idx, wdata[2:0], lvl, exp_mask, exp_pend, exp_ack}
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'b000, 3'b111, 3'b000, 3'b000, 3'b000}, // idle, masked lines
    {1'b1, 2'd1, 3'b001, 3'b111, 3'b001, 3'b000, 3'b000}, // enable rx
    {1'b0, 2'd0, 3'b000, 3'b111, 3'b001, 3'b001, 3'b000}, // rx latches
    {1'b1, 2'd1, 3'b110, 3'b000, 3'b111, 3'b001, 3'b000}, // enable rest, sticky
    {1'b0, 2'd0, 3'b000, 3'b100, 3'b111, 3'b101, 3'b000}, // txerr latches
    {1'b1, 2'd0, 3'b100, 3'b000, 3'b011, 3'b101, 3'b000}, // disable txerr, sticky
    {1'b1, 2'd3, 3'b010, 3'b000, 3'b011, 3'b101, 3'b000}, // release non-pending
    {1'b1, 2'd3, 3'b001, 3'b001, 3'b011, 3'b100, 3'b001}, // release rx, line high
    {1'b0, 2'd0, 3'b000, 3'b001, 3'b011, 3'b101, 3'b000}, // rx relatches
    {1'b1, 2'd2, 3'b111, 3'b000, 3'b011, 3'b101, 3'b000}, // write to view
    {1'b1, 2'd1, 3'b000, 3'b000, 3'b011, 3'b101, 3'b000}, // enable zeros
    {1'b1, 2'd0, 3'b000, 3'b000, 3'b011, 3'b101, 3'b000}, // disable zeros
    {1'b1, 2'd3, 3'b000, 3'b000, 3'b011, 3'b101, 3'b000}, // release zeros
    {1'b1, 2'd3, 3'b111, 3'b100, 3'b011, 3'b000, 3'b101}, // release all
    {1'b0, 2'd0, 3'b000, 3'b100, 3'b011, 3'b000, 3'b000}, // masked line stays out
    {1'b1, 2'd0, 3'b111, 3'b011, 3'b000, 3'b011, 3'b000}, // disable uses old mask
    {1'b1, 2'd3, 3'b111, 3'b011, 3'b000, 3'b000, 3'b011}, // release, no relatch
    {1'b0, 2'd0, 3'b000, 3'b111, 3'b000, 3'b000, 3'b000}  // all masked
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic s, input logic w, input logic [1:0] i,
                           input logic [31:0] d, input logic [2:0] l);
    @(negedge clk);
    acc_sel = s; acc_we = w; acc_idx = i; acc_wdata = d; src_lvl = l;
    @(posedge clk);
    #1;
    acc_sel = 1'b0; acc_we = 1'b0;
  endtask

  task automatic read_idx(input logic [1:0] i, output logic [31:0] v);
    acc_idx = i;
    #1;
    v = acc_rdata;
  endtask

  task automatic check_reset_state(input string tag);
    logic [31:0] v;
    check("R1", {tag, " mask"}, 32'(src_mask), 32'd0);
    check("R1", {tag, " ack"},  32'(src_ack),  32'd0);
    check("R1", {tag, " irq"},  32'(irq),      32'd0);
    for (int k = 0; k < 4; k++) begin
      read_idx(2'(k), v);
      check("R1", {tag, " read"}, v, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_reset_state("after reset");

    // vector table, R2 R3 R6 R7 R8 R9 R10
    for (int n = 0; n < NV; n++) begin
      logic [17:0] e;
      e = VEC[n];
      bus_cycle(e[17], e[17], e[16:15], {29'd0, e[14:12]}, e[11:9]);
      check("R9", $sformatf("vec%0d ack", n), 32'(src_ack), 32'(e[2:0]));
      check("R2/R3", $sformatf("vec%0d mask", n), 32'(src_mask), 32'(e[8:6]));
      check("R8", $sformatf("vec%0d irq", n), 32'(irq), 32'(e[5:3] != 3'b000));
      read_idx(2'd3, v);
      check("R6/R7", $sformatf("vec%0d pend", n), v, 32'(e[5:3]));
      read_idx(2'd2, v);
      check("R4", $sformatf("vec%0d view", n), v, 32'(e[8:6]));
    end

    // R10: unqualified strobes do nothing
    bus_cycle(1'b0, 1'b1, 2'd1, 32'h7, 3'b000);
    check("R10", "sel low enable", 32'(src_mask), 32'd0);
    bus_cycle(1'b1, 1'b0, 2'd1, 32'h7, 3'b000);
    check("R10", "we low enable", 32'(src_mask), 32'd0);

    // R2: data above bit 2 ignored
    bus_cycle(1'b1, 1'b1, 2'd1, 32'hFFFF_FFF8, 3'b000);
    check("R2", "upper data bits", 32'(src_mask), 32'd0);

    // R4 R5: view and write-only reads with a non-zero mask
    bus_cycle(1'b1, 1'b1, 2'd1, 32'h5, 3'b000);
    check("R4", "src_mask", 32'(src_mask), 32'd5);
    read_idx(2'd2, v);
    check("R4", "view read", v, 32'd5);
    read_idx(2'd0, v);
    check("R5", "disable read", v, 32'd0);
    read_idx(2'd1, v);
    check("R5", "enable read", v, 32'd0);

    // R6: pending survives the line falling
    bus_cycle(1'b0, 1'b0, 2'd3, 32'h0, 3'b001);
    bus_cycle(1'b0, 1'b0, 2'd3, 32'h0, 3'b000);
    read_idx(2'd3, v);
    check("R6", "sticky after line low", v, 32'd1);
    check("R8", "irq sticky", 32'(irq), 32'd1);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("during reset");
    @(negedge clk);
    rst_n = 1'b1;
    src_lvl = 3'b111;
    @(posedge clk);
    #1;
    read_idx(2'd3, v);
    check("R6", "no latch with reset mask", v, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule